// File: doc/BRIEF.md
# Even-Lane Widening Multiplier

This block is a SIMD execution unit. It multiplies unsigned 32-bit values and keeps each full 64-bit product. Each 64-bit quadword slot of the two source vectors contributes only its low 32-bit half. The two low halves are multiplied, and the product fills the same quadword slot of a 256-bit result. The upper halves of the slots are never read.

A two-bit mode select sets how many quadword slots are computed and what happens to the result bits above them:

- a single-slot 64-bit form;
- a 128-bit form that keeps the old upper destination;
- a 128-bit form that clears the upper destination;
- a full four-slot 256-bit form.

The issuing logic supplies the previous destination value on a separate port, so that bits outside the active width can be carried through unchanged. One length bit comes with every request. When that length bit is set on the clearing 128-bit form, the encoding is illegal. The unit then flags the request and does not commit any result. The unit is a fixed two-cycle pipeline. The mode and the merge data travel alongside the operands, so back-to-back requests are accepted on every cycle.

Top module: `even_lane_wmul`

## Requirements
- R1: For each computed slot k, result bits [64k+63:64k] equal the unsigned product of src_a[64k+31:64k] and src_b[64k+31:64k], full 64 bits wide.
- R2: Mode 0 (single-slot) computes slot 0 only, and result bits [255:64] equal old_dst[255:64].
- R3: Source bits [64k+63:64k+32] (the odd doublewords) have no effect on the result in any mode.
- R4: Modes 1 and 2 (both 128-bit forms) compute slots 0 and 1.
- R5: In mode 1 (128-bit, keep form), result bits [255:128] equal old_dst[255:128].
- R6: In mode 2 (128-bit, clear form), result bits [255:128] are zero.
- R7: Mode 3 (256-bit) computes all four slots.
- R8: Each product is confined to its own 64-bit slot, and nothing carries into the next slot. All-ones operands give 64'hFFFFFFFE00000001 in every computed slot.
- R9: A request in mode 2 with in_len = 1 is illegal. Two cycles later out_illegal pulses for one cycle, out_valid stays low, and out_result holds its previous value. in_len has no effect in modes 0, 1 and 3.
- R10: A legal request accepted with in_valid in cycle t gives out_valid = 1 for exactly one cycle, in cycle t+2. out_valid is low in cycle t+1.
- R11: During reset, out_valid and out_illegal are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | 0 single-slot, 1 128-bit keep, 2 128-bit clear, 3 256-bit |
| in_len | input | 1 | Length bit; illegal together with mode 2 |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| old_dst | input | 256 | Previous destination value, merged into inactive slots |
| out_valid | output | 1 | Result valid, two cycles after a legal request |
| out_illegal | output | 1 | Illegal-encoding pulse, two cycles after the request |
| out_result | output | 256 | Merged 256-bit result |

## Verification
The hardest case to reach from the ports is the illegal request. Its only visible effect on the data path is that nothing changes. The stimulus therefore sends an illegal request directly after a legal one whose result is known. The bench then checks that the earlier value is still on out_result while out_illegal is high. Ignored odd doublewords are also invisible unless they hold non-zero data. Every sweep therefore includes operands whose odd halves carry dense garbage, and the expected value is built from the even halves alone.

// File: rtl/ewm_pkg.sv
package ewm_pkg;

  typedef enum logic [1:0] {
    MODE_Q64    = 2'd0,
    MODE_KEEP128 = 2'd1,
    MODE_CLR128 = 2'd2,
    MODE_FULL   = 2'd3
  } ewm_mode_e;

  // number of quadword slots computed in a given mode
  function automatic int unsigned active_slots(input ewm_mode_e m, input int unsigned lanes);
    int unsigned n;
    case (m)
      MODE_Q64:     n = 1;
      MODE_KEEP128,
      MODE_CLR128:  n = (lanes < 2) ? lanes : 2;
      default:      n = lanes;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ewm_rst_sync.sv
module ewm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ewm_lane_mul.sv
module ewm_lane_mul #(
  parameter int DW = 32,
  localparam int PW = 2 * DW
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic [PW-1:0] prod
);

  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;

  always_comb begin
    a_ext = {{DW{1'b0}}, op_a};
    b_ext = {{DW{1'b0}}, op_b};
    prod  = a_ext * b_ext;
  end

endmodule

// File: rtl/ewm_upper_merge.sv
module ewm_upper_merge
  import ewm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int QW    = 64
) (
  input  ewm_mode_e                  mode,
  input  logic [LANES-1:0][QW-1:0]   prod,
  input  logic [LANES-1:0][QW-1:0]   old_val,
  output logic [LANES-1:0][QW-1:0]   merged
);

  int unsigned n_act;
  logic        clr_upper;

  always_comb begin
    n_act     = active_slots(mode, LANES);
    clr_upper = (mode == MODE_CLR128);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_slot
    always_comb begin
      if (l < n_act)      merged[l] = prod[l];
      else if (clr_upper) merged[l] = '0;
      else                merged[l] = old_val[l];
    end
  end

endmodule

// File: rtl/even_lane_wmul.sv
module even_lane_wmul
  import ewm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 32,
  localparam int QW   = 2 * DW,
  localparam int VW   = LANES * QW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_mode,
  input  logic          in_len,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [VW-1:0] old_dst,
  output logic          out_valid,
  output logic          out_illegal,
  output logic [VW-1:0] out_result
);

  logic rst_sync_n;

  ewm_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // ---------------- stage 1: capture even halves and side data
  ewm_mode_e             in_mode_e;
  logic                  in_bad;
  logic [LANES-1:0][DW-1:0] a_even, b_even;

  always_comb begin
    in_mode_e = ewm_mode_e'(in_mode);
    in_bad    = (in_mode_e == MODE_CLR128) && in_len;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_pick
    assign a_even[l] = src_a[l*QW +: DW];
    assign b_even[l] = src_b[l*QW +: DW];
  end

  logic                     s1_vld_q, s1_vld_d;
  logic                     s1_bad_q, s1_bad_d;
  ewm_mode_e                s1_mode_q;
  logic [LANES-1:0][DW-1:0] s1_a_q, s1_b_q;
  logic [VW-1:0]            s1_old_q;
  logic                     s1_en;

  always_comb begin
    s1_vld_d = in_valid;
    s1_bad_d = in_valid && in_bad;
    s1_en    = in_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_vld_q <= 1'b0;
      s1_bad_q <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s1_bad_q <= s1_bad_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_en) begin
      s1_mode_q <= in_mode_e;
      s1_a_q    <= a_even;
      s1_b_q    <= b_even;
      s1_old_q  <= old_dst;
    end
  end

  // ---------------- multiply and merge
  logic [LANES-1:0][QW-1:0] prod;
  logic [LANES-1:0][QW-1:0] old_slots;
  logic [LANES-1:0][QW-1:0] merged;

  for (genvar l = 0; l < LANES; l++) begin : g_mul
    ewm_lane_mul #(.DW(DW)) mul_i (
      .op_a(s1_a_q[l]),
      .op_b(s1_b_q[l]),
      .prod(prod[l])
    );
    assign old_slots[l] = s1_old_q[l*QW +: QW];
  end

  ewm_upper_merge #(.LANES(LANES), .QW(QW)) merge_i (
    .mode   (s1_mode_q),
    .prod   (prod),
    .old_val(old_slots),
    .merged (merged)
  );

  // ---------------- stage 2: commit
  logic          s2_vld_q, s2_vld_d;
  logic          s2_bad_q, s2_bad_d;
  logic [VW-1:0] s2_res_q;
  logic          s2_en;

  always_comb begin
    s2_vld_d = s1_vld_q && !s1_bad_q;
    s2_bad_d = s1_vld_q && s1_bad_q;
    s2_en    = s2_vld_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s2_vld_q <= 1'b0;
      s2_bad_q <= 1'b0;
    end else begin
      s2_vld_q <= s2_vld_d;
      s2_bad_q <= s2_bad_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_en) s2_res_q <= merged;
  end

  assign out_valid   = s2_vld_q;
  assign out_illegal = s2_bad_q;
  assign out_result  = s2_res_q;

endmodule

// File: rtl/ewm_chk.sv
module ewm_chk #(
  parameter int LANES = 4,
  parameter int DW    = 32,
  localparam int QW   = 2 * DW,
  localparam int VW   = LANES * QW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    in_mode,
  input logic          in_len,
  input logic [VW-1:0] src_a,
  input logic [VW-1:0] src_b,
  input logic [VW-1:0] old_dst,
  input logic          out_valid,
  input logic          out_illegal,
  input logic [VW-1:0] out_result
);

  // R10
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R10
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && !(in_mode == 2'd2 && in_len), 2) |-> out_valid);

  // R9
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_mode == 2'd2 && in_len, 2) |-> (out_illegal && !out_valid));

  // R9
  illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal));

  // R9
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> $stable(out_result));

  // R6
  clr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_mode == 2'd2, 2)) |-> (out_result[VW-1:2*QW] == '0));

  // R5
  keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_mode == 2'd1, 2)) |-> (out_result[VW-1:2*QW] == $past(old_dst[VW-1:2*QW], 2)));

  // R1
  slot0_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[QW-1:0] ==
                   (QW'($past(src_a[DW-1:0], 2)) * QW'($past(src_b[DW-1:0], 2)))));

endmodule

bind even_lane_wmul ewm_chk #(.LANES(LANES), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .in_mode    (in_mode),
  .in_len     (in_len),
  .src_a      (src_a),
  .src_b      (src_b),
  .old_dst    (old_dst),
  .out_valid  (out_valid),
  .out_illegal(out_illegal),
  .out_result (out_result)
);

// File: tb/even_lane_wmul_tb_top.sv
`timescale 1ns/1ps
module even_lane_wmul_tb_top;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   in_mode;
  logic         in_len;
  logic [255:0] src_a, src_b, old_dst;
  logic         out_valid, out_illegal;
  logic [255:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [255:0] last_good;

  even_lane_wmul dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_len(in_len), .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [255:0] model(input logic [1:0] m, input logic [255:0] a,
                                         input logic [255:0] b, input logic [255:0] old);
    logic [255:0] r;
    int n;
    r = old;
    n = (m == 2'd0) ? 1 : (m == 2'd3) ? 4 : 2;
    for (int l = 0; l < 4; l++) begin
      if (l < n)           r[l*64 +: 64] = {32'b0, a[l*64 +: 32]} * {32'b0, b[l*64 +: 32]};
      else if (m == 2'd2)  r[l*64 +: 64] = 64'd0;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R4,R5";
      2'd2: return "R4,R6";
      default: return "R7";
    endcase
  endfunction

  task automatic do_op(input logic [1:0] m, input logic len, input logic [255:0] a,
                       input logic [255:0] b, input logic [255:0] old, input string ptag);
    logic [255:0] exp;
    bit bad;
    bad = (m == 2'd2) && len;
    exp = bad ? last_good : model(m, a, b, old);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_len = len; src_a = a; src_b = b; old_dst = old;
    @(negedge clk);
    in_valid = 1'b0;
    src_a = ~a; src_b = ~b; old_dst = ~old;
    // R10: nothing emerges after one cycle
    chk(!out_valid && !out_illegal, "R10 early", {254'd0, out_valid, out_illegal}, 256'd0);
    @(negedge clk);
    if (bad) begin
      // R9
      chk(out_illegal && !out_valid, "R9 flag", {254'd0, out_valid, out_illegal}, 256'd1);
      chk(out_result == exp, "R9 hold", out_result, exp);
    end else begin
      chk(out_valid && !out_illegal, "R10 valid", {254'd0, out_valid, out_illegal}, 256'd2);
      chk(out_result == exp, {mode_tag(m), " ", ptag}, out_result, exp);
      last_good = exp;
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [255:0] zap_odd(input logic [255:0] v);
    logic [255:0] r;
    r = v;
    for (int l = 0; l < 4; l++) r[l*64+32 +: 32] = 32'd0;
    return r;
  endfunction

  initial begin
    in_valid = 1'b0; in_mode = 2'd0; in_len = 1'b0;
    src_a = '0; src_b = '0; old_dst = '0; last_good = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11
    chk(!out_valid && !out_illegal, "R11 reset", {254'd0, out_valid, out_illegal}, 256'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_valid && !out_illegal, "R11 idle", {254'd0, out_valid, out_illegal}, 256'd0);

    for (int mi = 0; mi < 4; mi++) begin
      for (int li = 0; li < 2; li++) begin
        logic [255:0] a, b, o;
        o = rnd256();
        do_op(mi[1:0], li[0], '0, '0, o, "R1 zero");
        do_op(mi[1:0], li[0], '1, '1, o, "R8 ones");
        a = rnd256(); b = rnd256();
        // R3: garbage odd halves vs. clean odd halves give the same result
        do_op(mi[1:0], li[0], a, b, o, "R3 garbage");
        do_op(mi[1:0], li[0], zap_odd(a), zap_odd(b), o, "R3 clean");
        for (int k = 0; k < 32; k += 5)
          do_op(mi[1:0], li[0], {4{32'hA5A5_5A5A, 32'd1 << k}}, {4{32'h1234_5678, ~(32'd1 << k)}},
                o, "R1 walk");
        for (int r = 0; r < 10; r++)
          do_op(mi[1:0], li[0], rnd256(), rnd256(), rnd256(), "R1 random");
      end
    end

    // R9: illegal directly after a known legal result
    do_op(2'd3, 1'b0, rnd256(), rnd256(), rnd256(), "R7 pre");
    do_op(2'd2, 1'b1, rnd256(), rnd256(), rnd256(), "R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule